// File: doc/BRIEF.md
# Dual-Channel Memory Self-Test Controller

This block runs a march-style self-test over two on-chip RAMs, one holding instructions and one holding data. Both channels are controlled through one 32-bit control word. A write to the word sets each channel's test span, its enable and its pause. The same write can also start a channel by setting its strobe bit. A read of the word returns the stored settings next to live status for each channel: running, complete and fail.

Each channel has its own test engine, which owns a synchronous single-port RAM interface. The engine writes a fixed pattern to every word of the span in ascending order. It then reads every word back and compares it with the pattern. It repeats both passes with the bitwise inverse of the pattern. Any mismatch latches a fail flag, which stays set until the next start. The two channels run independently and may run at the same time.

Top module: `membist_ctrl`

## Requirements
- R1: The control word holds two 16-bit channel fields: data in bits [15:0] and instruction in bits [31:16]. Within a field, [15:5] is the span exponent N, [4] complete, [3] fail, [2] enable, [1] pause and [0] run. On read, N, enable and pause return the value last written. After reset the whole word reads zero.
- R2: Written values in the complete and fail positions have no effect. Those read bits change only through test progress.
- R3: A 1 in a channel's run position starts that channel only if that channel's enable is 1 in the same write or was already 1. Without enable, the strobe causes no RAM access and running stays 0.
- R4: A run strobe that arrives while the channel is running is ignored. The test continues without restarting.
- R5: A test covers word addresses 0 to 2^E−1, where E = min(N, ADDR_W), so N=0 tests one word. The engine makes one access per cycle in four ascending passes: write PATTERN, read, write ~PATTERN, read.
- R6: N above ADDR_W, which includes every N above 24, is clamped to the full RAM depth. The read value of N stays the written value.
- R7: While a channel's pause bit is 1, that channel makes no RAM access and holds its address and pass. When pause returns to 0, the test continues from the same point.
- R8: Read data is compared one cycle after the read is issued. A mismatch sets the channel's fail bit, which stays 1 until the next start.
- R9: Running reads 1 from the cycle after the starting write. On the edge that ends the cycle after the last compare read, running clears and complete sets. A start clears complete and fail.
- R10: The two channels are independent. Either channel can be started, paused or failed while the other runs.
- R11: A RAM enable is active only while its channel is running and not paused. The write enable is active only in the write passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 32 | Control word write value |
| reg_rd_data | output | 32 | Control word read value (settings and status) |
| iram_en | output | 1 | Instruction RAM access enable |
| iram_we | output | 1 | Instruction RAM write enable |
| iram_addr | output | ADDR_W | Instruction RAM word address |
| iram_wdata | output | DATA_W | Instruction RAM write data |
| iram_rdata | input | DATA_W | Instruction RAM read data, valid one cycle after a read |
| dram_en | output | 1 | Data RAM access enable |
| dram_we | output | 1 | Data RAM write enable |
| dram_addr | output | ADDR_W | Data RAM word address |
| dram_wdata | output | DATA_W | Data RAM write data |
| dram_rdata | input | DATA_W | Data RAM read data, valid one cycle after a read |

## Verification
The assertions check several relations on every cycle:
- a RAM is never accessed unless its channel reads as running, and never while it reads as paused;
- a paused channel keeps its address;
- complete and running are never 1 together;
- complete rises only just after running falls;
- fail never drops unless the control word is written.

Only the bench scenarios can show the rest: the exact address and data order of the four passes, the span clamping, that a disabled or repeated strobe is ignored, that a stuck RAM bit is detected, and that both channels run together. The cycle-level reference model covers these.

// File: rtl/membist_pkg.sv
package membist_pkg;

    localparam int unsigned NUM_CH   = 2;
    localparam int unsigned CH_DATA  = 0;   // control bits [15:0]
    localparam int unsigned CH_INSTR = 1;   // control bits [31:16]
    localparam int unsigned FIELD_W  = 16;
    localparam int unsigned SIZE_W   = 11;

    // One channel's 16-bit slice of the control word (bit order is the interface)
    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic              done;
        logic              fail;
        logic              en;
        logic              pause;
        logic              run;
    } chan_word_t;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic              en;
        logic              pause;
    } chan_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WR_TRUE,
        PH_RD_TRUE,
        PH_WR_INV,
        PH_RD_INV,
        PH_DRAIN
    } phase_e;

    // Last word address for exponent n, clamped to an address width of aw
    function automatic int unsigned span_last(input logic [SIZE_W-1:0] n,
                                              input int unsigned aw);
        int unsigned e;
        e = (int'(n) > int'(aw)) ? aw : int'(n);
        return (32'd1 << e) - 32'd1;
    endfunction

    function automatic phase_e next_pass(input phase_e p);
        case (p)
            PH_WR_TRUE: return PH_RD_TRUE;
            PH_RD_TRUE: return PH_WR_INV;
            PH_WR_INV:  return PH_RD_INV;
            PH_RD_INV:  return PH_DRAIN;
            default:    return PH_IDLE;
        endcase
    endfunction

    function automatic logic is_active(input phase_e p);
        return (p == PH_WR_TRUE) || (p == PH_RD_TRUE) ||
               (p == PH_WR_INV)  || (p == PH_RD_INV);
    endfunction

    function automatic logic is_write(input phase_e p);
        return (p == PH_WR_TRUE) || (p == PH_WR_INV);
    endfunction

    function automatic logic is_inverted(input phase_e p);
        return (p == PH_WR_INV) || (p == PH_RD_INV);
    endfunction

endpackage

// File: rtl/membist_regs.sv
module membist_regs
    import membist_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [31:0]                    wr_data,
    input  logic [NUM_CH-1:0]              run_st,
    input  logic [NUM_CH-1:0]              done_st,
    input  logic [NUM_CH-1:0]              fail_st,
    output chan_cfg_t [NUM_CH-1:0]         cfg,
    output logic [NUM_CH-1:0]              start_req,
    output logic [NUM_CH-1:0][SIZE_W-1:0]  start_size,
    output logic [31:0]                    rd_data
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_word_t wr_slice;
        chan_word_t rd_slice;
        chan_cfg_t  cfg_q;
        logic       unused_sbz;

        assign wr_slice = chan_word_t'(wr_data[c*FIELD_W +: FIELD_W]);
        // complete/fail positions are status only; written values are dropped
        assign unused_sbz = wr_slice.done ^ wr_slice.fail;

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q <= '0;
            end else if (wr_en) begin
                cfg_q.size  <= wr_slice.size;
                cfg_q.en    <= wr_slice.en;
                cfg_q.pause <= wr_slice.pause;
            end
        end

        assign start_req[c]  = wr_en && wr_slice.run && (wr_slice.en || cfg_q.en);
        assign start_size[c] = wr_slice.size;
        assign cfg[c]        = cfg_q;

        always_comb begin
            rd_slice.size  = cfg_q.size;
            rd_slice.done  = done_st[c];
            rd_slice.fail  = fail_st[c];
            rd_slice.en    = cfg_q.en;
            rd_slice.pause = cfg_q.pause;
            rd_slice.run   = run_st[c];
        end

        assign rd_data[c*FIELD_W +: FIELD_W] = rd_slice;
    end

endmodule

// File: rtl/membist_engine.sv
module membist_engine
    import membist_pkg::*;
#(
    parameter int unsigned       ADDR_W  = 10,
    parameter int unsigned       DATA_W  = 32,
    parameter logic [DATA_W-1:0] PATTERN = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SIZE_W-1:0] start_size,
    input  logic              pause,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              running,
    output logic              done,
    output logic              fail
);

    phase_e            phase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] last_q;
    logic              cmp_pend_q;
    logic [DATA_W-1:0] cmp_exp_q;
    logic              done_q;
    logic              fail_q;

    logic              issue;
    logic [DATA_W-1:0] pass_data;

    assign issue     = is_active(phase_q) && !pause;
    assign pass_data = is_inverted(phase_q) ? ~PATTERN : PATTERN;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            addr_q     <= '0;
            last_q     <= '0;
            cmp_pend_q <= 1'b0;
            cmp_exp_q  <= '0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
        end else begin
            cmp_pend_q <= issue && !is_write(phase_q);
            cmp_exp_q  <= pass_data;
            if (cmp_pend_q && (ram_rdata != cmp_exp_q)) begin
                fail_q <= 1'b1;
            end
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_WR_TRUE;
                        addr_q  <= '0;
                        last_q  <= ADDR_W'(span_last(start_size, ADDR_W));
                        done_q  <= 1'b0;
                        fail_q  <= 1'b0;
                    end
                end
                PH_DRAIN: begin
                    phase_q <= PH_IDLE;
                    done_q  <= 1'b1;
                end
                default: begin
                    if (issue) begin
                        if (addr_q == last_q) begin
                            addr_q  <= '0;
                            phase_q <= next_pass(phase_q);
                        end else begin
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign ram_en    = issue;
    assign ram_we    = issue && is_write(phase_q);
    assign ram_addr  = addr_q;
    assign ram_wdata = pass_data;
    assign running   = (phase_q != PH_IDLE);
    assign done      = done_q;
    assign fail      = fail_q;

endmodule

// File: rtl/membist_ctrl.sv
module membist_ctrl
    import membist_pkg::*;
#(
    parameter int unsigned       ADDR_W  = 10,
    parameter int unsigned       DATA_W  = 32,
    parameter logic [DATA_W-1:0] PATTERN = DATA_W'(32'h5AC3_96E1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wr_data,
    output logic [31:0]       reg_rd_data,
    output logic              iram_en,
    output logic              iram_we,
    output logic [ADDR_W-1:0] iram_addr,
    output logic [DATA_W-1:0] iram_wdata,
    input  logic [DATA_W-1:0] iram_rdata,
    output logic              dram_en,
    output logic              dram_we,
    output logic [ADDR_W-1:0] dram_addr,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);

    chan_cfg_t [NUM_CH-1:0]          cfg;
    logic [NUM_CH-1:0]               start_req;
    logic [NUM_CH-1:0][SIZE_W-1:0]   start_size;
    logic [NUM_CH-1:0]               run_st, done_st, fail_st;
    logic [NUM_CH-1:0]               en_v, we_v;
    logic [NUM_CH-1:0][ADDR_W-1:0]   addr_v;
    logic [NUM_CH-1:0][DATA_W-1:0]   wdata_v, rdata_v;

    membist_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .wr_data    (reg_wr_data),
        .run_st     (run_st),
        .done_st    (done_st),
        .fail_st    (fail_st),
        .cfg        (cfg),
        .start_req  (start_req),
        .start_size (start_size),
        .rd_data    (reg_rd_data)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_eng
        membist_engine #(
            .ADDR_W  (ADDR_W),
            .DATA_W  (DATA_W),
            .PATTERN (PATTERN)
        ) u_eng (
            .clk        (clk),
            .rst        (rst),
            .start      (start_req[c]),
            .start_size (start_size[c]),
            .pause      (cfg[c].pause),
            .ram_en     (en_v[c]),
            .ram_we     (we_v[c]),
            .ram_addr   (addr_v[c]),
            .ram_wdata  (wdata_v[c]),
            .ram_rdata  (rdata_v[c]),
            .running    (run_st[c]),
            .done       (done_st[c]),
            .fail       (fail_st[c])
        );
    end

    assign rdata_v[CH_INSTR] = iram_rdata;
    assign rdata_v[CH_DATA]  = dram_rdata;

    assign iram_en    = en_v[CH_INSTR];
    assign iram_we    = we_v[CH_INSTR];
    assign iram_addr  = addr_v[CH_INSTR];
    assign iram_wdata = wdata_v[CH_INSTR];
    assign dram_en    = en_v[CH_DATA];
    assign dram_we    = we_v[CH_DATA];
    assign dram_addr  = addr_v[CH_DATA];
    assign dram_wdata = wdata_v[CH_DATA];

endmodule

// File: rtl/membist_ctrl_chk.sv
module membist_ctrl_chk #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [31:0]       reg_rd_data,
    input logic              iram_en,
    input logic [ADDR_W-1:0] iram_addr,
    input logic              dram_en,
    input logic [ADDR_W-1:0] dram_addr
);

    logic unused_size;
    assign unused_size = ^{reg_rd_data[31:21], reg_rd_data[15:5]};

    // R11
    i_access_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        iram_en |-> reg_rd_data[16]);

    // R11
    d_access_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        dram_en |-> reg_rd_data[0]);

    // R7
    i_pause_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[17] |-> !iram_en);

    // R7
    d_pause_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[1] |-> !dram_en);

    // R7
    d_pause_holds_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[1] && reg_rd_data[0] && !reg_wr_en) |=> $stable(dram_addr));

    // R7
    i_pause_holds_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[17] && reg_rd_data[16] && !reg_wr_en) |=> $stable(iram_addr));

    // R9
    d_done_excl_run_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd_data[4] && reg_rd_data[0]));

    // R9
    i_done_excl_run_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd_data[20] && reg_rd_data[16]));

    // R9
    d_run_fall_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(reg_rd_data[0]) |-> reg_rd_data[4]);

    // R2
    d_done_from_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_rd_data[4]) |-> $past(reg_rd_data[0]));

    // R2
    i_done_from_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_rd_data[20]) |-> $past(reg_rd_data[16]));

    // R8
    d_fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[3] && !reg_wr_en) |=> reg_rd_data[3]);

    // R8
    i_fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[19] && !reg_wr_en) |=> reg_rd_data[19]);

endmodule

bind membist_ctrl membist_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_data (reg_rd_data),
    .iram_en     (iram_en),
    .iram_addr   (iram_addr),
    .dram_en     (dram_en),
    .dram_addr   (dram_addr)
);

// File: tb/tb_membist_ctrl.sv
`timescale 1ns/1ps
module tb_membist_ctrl;

    localparam int AW    = 10;
    localparam int DW    = 32;
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] PAT = 32'h5AC3_96E1;
    localparam logic [DW-1:0] STUCK = 32'h0000_0002;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr_en = 1'b0;
    logic [31:0]   reg_wr_data = '0;
    logic [31:0]   reg_rd_data;
    logic          iram_en, iram_we, dram_en, dram_we;
    logic [AW-1:0] iram_addr, dram_addr;
    logic [DW-1:0] iram_wdata, iram_rdata, dram_wdata, dram_rdata;

    always #4 clk = ~clk;   // 125 MHz

    membist_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data),
        .iram_en(iram_en), .iram_we(iram_we), .iram_addr(iram_addr),
        .iram_wdata(iram_wdata), .iram_rdata(iram_rdata),
        .dram_en(dram_en), .dram_we(dram_we), .dram_addr(dram_addr),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    // ---------------- bench RAMs, optional stuck-at-1 fault ----------------
    logic [DW-1:0] imem [DEPTH];
    logic [DW-1:0] dmem [DEPTH];
    bit  fault_on [2];          // index 0 = data, 1 = instruction
    int  fault_addr = 1;

    always @(posedge clk) begin
        if (iram_en && iram_we)
            imem[iram_addr] <= iram_wdata | ((fault_on[1] && iram_addr == fault_addr) ? STUCK : '0);
        if (iram_en && !iram_we) iram_rdata <= imem[iram_addr];
        if (dram_en && dram_we)
            dmem[dram_addr] <= dram_wdata | ((fault_on[0] && dram_addr == fault_addr) ? STUCK : '0);
        if (dram_en && !dram_we) dram_rdata <= dmem[dram_addr];
    end

    // ---------------- behavioural reference model ----------------
    int m_size[2], m_idx[2], m_words[2];
    bit m_en[2], m_pause[2], m_run[2], m_drain[2], m_done[2], m_fail[2], m_pend[2], m_pbad[2];

    function automatic int words_of(input int n);
        int e;
        e = (n > AW) ? AW : n;
        return 1 << e;
    endfunction

    function automatic logic [DW-1:0] pass_pat(input int pass);
        return (pass >= 2) ? ~PAT : PAT;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_size[c] <= 0; m_idx[c] <= 0; m_words[c] <= 1;
                m_en[c] <= 0; m_pause[c] <= 0; m_run[c] <= 0; m_drain[c] <= 0;
                m_done[c] <= 0; m_fail[c] <= 0; m_pend[c] <= 0; m_pbad[c] <= 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                logic [15:0] h;
                bit acc, rd;
                int pass;
                h    = reg_wr_data[c*16 +: 16];
                acc  = m_run[c] && !m_drain[c] && !m_pause[c];
                pass = m_idx[c] / m_words[c];
                rd   = acc && (pass == 1 || pass == 3);
                m_pend[c] <= rd;
                m_pbad[c] <= rd && fault_on[c] && ((m_idx[c] % m_words[c]) == fault_addr)
                             && ((pass_pat(pass) | STUCK) != pass_pat(pass));
                if (m_pend[c] && m_pbad[c]) m_fail[c] <= 1;
                if (reg_wr_en && h[0] && (h[2] || m_en[c]) && !m_run[c]) begin
                    m_run[c] <= 1; m_drain[c] <= 0; m_idx[c] <= 0;
                    m_words[c] <= words_of(int'(h[15:5]));
                    m_done[c] <= 0; m_fail[c] <= 0;
                end else if (m_run[c]) begin
                    if (m_drain[c]) begin
                        m_run[c] <= 0; m_drain[c] <= 0; m_done[c] <= 1;
                    end else if (acc) begin
                        if (m_idx[c] == 4*m_words[c]-1) m_drain[c] <= 1;
                        m_idx[c] <= m_idx[c] + 1;
                    end
                end
                if (reg_wr_en) begin
                    m_size[c] <= int'(h[15:5]); m_en[c] <= h[2]; m_pause[c] <= h[1];
                end
            end
        end
    end

    // ---------------- checking ----------------
    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_word();
        logic [31:0] w;
        for (int c = 0; c < 2; c++)
            w[c*16 +: 16] = {11'(m_size[c]), m_done[c], m_fail[c], m_en[c], m_pause[c], m_run[c]};
        return w;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(reg_rd_data == model_word(), "R1/R9 control word", reg_rd_data, model_word());
            for (int c = 0; c < 2; c++) begin
                bit e_en;
                int pass;
                logic          a_en, a_we;
                logic [AW-1:0] a_addr;
                logic [DW-1:0] a_wd;
                e_en = m_run[c] && !m_drain[c] && !m_pause[c];
                pass = m_idx[c] / m_words[c];
                a_en   = (c == 1) ? iram_en    : dram_en;
                a_we   = (c == 1) ? iram_we    : dram_we;
                a_addr = (c == 1) ? iram_addr  : dram_addr;
                a_wd   = (c == 1) ? iram_wdata : dram_wdata;
                check(a_en == e_en, "R11 ram enable", 32'(a_en), 32'(e_en));
                if (e_en && a_en) begin
                    check(a_we == (pass == 0 || pass == 2), "R5 write enable", 32'(a_we),
                          32'(pass == 0 || pass == 2));
                    check(int'(a_addr) == m_idx[c] % m_words[c], "R5 address", 32'(a_addr),
                          32'(m_idx[c] % m_words[c]));
                    if (a_we)
                        check(a_wd == pass_pat(pass), "R5 write data", a_wd, pass_pat(pass));
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    logic [15:0] ih = '0, dh = '0;   // shadow of written settings (run bit 0)

    function automatic logic [15:0] mk(input int n, input bit en, input bit pz);
        return {11'(n), 2'b00, en, pz, 1'b0};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wreg(input logic [31:0] w);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_wr_data = w;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; reg_wr_data = '0;
    endtask

    task automatic wait_idle(input int c);
        int guard;
        guard = 0;
        while (m_run[c] && guard < 20000) begin tick(1); guard++; end
        tick(1);
    endtask

    task automatic sample();
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        for (int i = 0; i < DEPTH; i++) begin imem[i] = '0; dmem[i] = '0; end
        iram_rdata = '0; dram_rdata = '0;
        fault_on[0] = 0; fault_on[1] = 0;
        tick(3); rst = 1'b0;
        sample();
        // R1 reset state
        check(reg_rd_data == 32'h0, "R1 reset word", reg_rd_data, 32'h0);
        check({iram_en, dram_en} == 2'b00, "R11 reset idle", 32'({iram_en, dram_en}), 32'h0);

        // R1 / R2: settings read back, written complete/fail ignored
        ih = mk(3, 1, 1); dh = mk(5, 0, 1);
        wreg({ih | 16'h0018, dh | 16'h0018});
        sample();
        check(reg_rd_data == {ih, dh}, "R2 status bits not writable", reg_rd_data, {ih, dh});
        ih = mk(3, 0, 0); dh = mk(5, 0, 0);
        wreg({ih, dh});
        sample();
        check(reg_rd_data == {ih, dh}, "R1 settings readback", reg_rd_data, {ih, dh});

        // R3: strobe without enable does nothing
        wreg({ih, dh | 16'h0001});
        tick(3); sample();
        check(reg_rd_data[0] == 1'b0, "R3 no start without enable", 32'(reg_rd_data[0]), 32'h0);
        check(dram_en == 1'b0, "R3 no access without enable", 32'(dram_en), 32'h0);

        // R3 / R5 / R9: enable already set, then strobe alone (data N=2, 4 words)
        dh = mk(2, 1, 0);
        wreg({ih, dh});
        wreg({ih, dh & 16'hFFFB | 16'h0001});  // enable 0 in this write, already 1
        dh = mk(2, 0, 0);
        sample();
        check(reg_rd_data[0] == 1'b1, "R3 start with earlier enable", 32'(reg_rd_data[0]), 32'h1);
        wait_idle(0); sample();
        check(reg_rd_data[4:3] == 2'b10, "R9 complete without fail", 32'(reg_rd_data[4:3]), 32'h2);

        // R5: N=0 tests one word, 5 running cycles
        dh = mk(0, 1, 0);
        wreg({ih, dh | 16'h0001});
        tick(4); sample();
        check(reg_rd_data[0] == 1'b1, "R9 running through drain", 32'(reg_rd_data[0]), 32'h1);
        tick(1); sample();
        check(reg_rd_data[4] == 1'b1, "R5 one-word span complete", 32'(reg_rd_data[4]), 32'h1);

        // R4: repeat strobe while running ignored (instruction N=3)
        ih = mk(3, 1, 0);
        wreg({ih | 16'h0001, dh});
        tick(5);
        wreg({ih | 16'h0001, dh});
        sample();
        check(iram_addr != '0 || iram_we == 1'b0, "R4 no restart", 32'(iram_addr), 32'h1);
        wait_idle(1); sample();
        check(reg_rd_data[20] == 1'b1, "R4 completes once", 32'(reg_rd_data[20]), 32'h1);

        // R7: pause mid-run holds point, then resumes (data N=6)
        begin
            logic [AW-1:0] held;
            dh = mk(6, 1, 0);
            wreg({ih, dh | 16'h0001});
            tick(20);
            dh = mk(6, 1, 1);
            wreg({ih, dh});
            sample(); held = dram_addr;
            for (int k = 0; k < 6; k++) begin
                sample();
                check(dram_en == 1'b0, "R7 no access while paused", 32'(dram_en), 32'h0);
                check(dram_addr == held, "R7 address held", 32'(dram_addr), 32'(held));
            end
            dh = mk(6, 1, 0);
            wreg({ih, dh});
            sample();
            check(dram_en == 1'b1, "R7 resumes after pause", 32'(dram_en), 32'h1);
            wait_idle(0); sample();
            check(reg_rd_data[4:3] == 2'b10, "R7 paused run completes clean",
                  32'(reg_rd_data[4:3]), 32'h2);
        end

        // R8: stuck bit on data RAM word 1 detected
        fault_on[0] = 1;
        dh = mk(3, 1, 0);
        wreg({ih, dh | 16'h0001});
        wait_idle(0); sample();
        check(reg_rd_data[4:3] == 2'b11, "R8 fail latched", 32'(reg_rd_data[4:3]), 32'h3);
        tick(3); sample();
        check(reg_rd_data[3] == 1'b1, "R8 fail sticky", 32'(reg_rd_data[3]), 32'h1);
        fault_on[0] = 0;
        wreg({ih, dh | 16'h0001});
        sample();
        check(reg_rd_data[4:3] == 2'b00, "R9 start clears flags", 32'(reg_rd_data[4:3]), 32'h0);
        wait_idle(0); sample();
        check(reg_rd_data[4:3] == 2'b10, "R8 clean rerun passes", 32'(reg_rd_data[4:3]), 32'h2);

        // R6: oversize exponent clamps to depth, value reads back
        dh = mk(30, 1, 0);
        wreg({ih, dh | 16'h0001});
        sample();
        check(reg_rd_data[15:5] == 11'd30, "R6 size readback", 32'(reg_rd_data[15:5]), 32'd30);
        wait_idle(0); sample();
        check(reg_rd_data[4] == 1'b1, "R6 clamped run completes", 32'(reg_rd_data[4]), 32'h1);
        dh = mk(12, 1, 0);
        wreg({ih, dh | 16'h0001});
        wait_idle(0); sample();
        check(reg_rd_data[15:0] == (dh | 16'h0010), "R6 exponent above depth",
              32'(reg_rd_data[15:0]), 32'(dh | 16'h0010));

        // R10: both channels together, instruction faulty, data clean
        fault_on[1] = 1;
        ih = mk(4, 1, 0); dh = mk(5, 1, 0);
        wreg({ih | 16'h0001, dh | 16'h0001});
        sample();
        check(reg_rd_data[16] && reg_rd_data[0], "R10 both running",
              32'({reg_rd_data[16], reg_rd_data[0]}), 32'h3);
        wait_idle(0); wait_idle(1); sample();
        check(reg_rd_data[20:19] == 2'b11, "R10 instruction fail", 32'(reg_rd_data[20:19]), 32'h3);
        check(reg_rd_data[4:3] == 2'b10, "R10 data unaffected", 32'(reg_rd_data[4:3]), 32'h2);
        fault_on[1] = 0;

        tick(2);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule